// File: doc/BRIEF.md
# Transport Stream Output Formatter

The formatter accepts decoded transport packets one byte at a time over a valid/ready handshake. A start-of-packet marker and a per-packet "correction failed" flag travel with the bytes. It checks the packet framing and presents each accepted byte on one of two output ports. The parallel port has an 8-bit bus, an output clock, a data-enable strobe, a packet-sync pulse and an uncorrectable flag. The serial port sends the same byte most significant bit first on one wire, with its own clock, enable, sync and error lines. Configuration inputs are static while traffic flows: the port mode and two inhibit bits.

Two state machines make up the block. The lock machine sits in the framer and has two states. **LK_HUNT** discards bytes until a start marker carrying the sync value arrives; the transition *acquire* moves it to **LK_TRACK**. **LK_TRACK** counts bytes within the packet. Its transitions are *restart* (a marker carrying the sync value, which stays in LK_TRACK), *lose* (a bad marker, or a missing marker where a packet should begin, which returns to LK_HUNT) and *advance* (an ordinary byte). The emit machine sits in the output stage and has three states. **EM_IDLE** holds the handshake ready; the transition *load* moves to **EM_LOW**. **EM_LOW** presents a byte or bit with the output clock low; *rise* moves to **EM_HIGH**. **EM_HIGH** raises the output clock. From there, *next_bit* returns to EM_LOW while serial bits remain, and *done* returns to EM_IDLE.

When a packet failed correction, its uncorrectable flag covers every byte of it. Unless an inhibit bit is set, the transport error indicator (the most significant bit of the byte after the sync byte) is forced to 1.

Top module: `ts_out_fmt`

## Requirements
- R1: A packet of 188 bytes whose first byte is 0x47 and carries the start marker is forwarded in order, with every byte unchanged apart from R4.
- R2: The sync output (par_sync or ser_sync) is high while the 0x47 first byte of a packet is presented and low for the other 187 bytes.
- R3: The uncorrectable output is high for all 188 bytes of a packet whose in_uncor was 1 at its sync byte, and low for all bytes of other packets.
- R4: In an uncorrectable packet, bit 7 of the byte after the sync byte is forced to 1 when cfg_rs_inhibit and cfg_tei_inhibit are both 0. If either is 1, that byte passes unchanged.
- R5: In parallel mode, each accepted byte occupies one cycle with par_clk low, then one cycle with par_clk high, and par_den is high for both. When par_den is low, par_data holds its last value and par_sync and par_uncor are low; the same rule holds for ser_sync and ser_uncor when ser_den is low. in_ready is high only between output slots.
- R6: in_uncor is sampled only with the sync byte. Changes during the rest of a packet have no effect.
- R7: In serial mode (cfg_serial=1), each byte is sent MSB first over 8 ser_clk periods of two cycles each. ser_data changes only where ser_clk falls or at the start of a byte, and ser_sync and ser_uncor are held for all 8 bits.
- R8: In serial mode, par_den stays low. In parallel mode (cfg_serial=0), ser_den stays low.
- R9: frame_err pulses for one cycle, and the byte is dropped, for each of these: a start marker whose byte is not 0x47; a non-marker byte where a packet should begin, after which bytes are dropped silently until a valid marker; a valid marker before 188 bytes, which is still forwarded as the new packet's sync byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_serial | input | 1 | 1 selects the serial port, 0 the parallel port |
| cfg_rs_inhibit | input | 1 | Inhibits error-indicator forcing |
| cfg_tei_inhibit | input | 1 | Inhibits error-indicator forcing |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Formatter can take a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_uncor | input | 1 | Packet failed correction (read at the sync byte) |
| par_data | output | 8 | Parallel data bus |
| par_clk | output | 1 | Parallel output clock |
| par_den | output | 1 | Parallel data enable |
| par_sync | output | 1 | Parallel sync pulse |
| par_uncor | output | 1 | Parallel uncorrectable flag |
| ser_data | output | 1 | Serial data |
| ser_clk | output | 1 | Serial output clock |
| ser_den | output | 1 | Serial data enable |
| ser_sync | output | 1 | Serial sync |
| ser_uncor | output | 1 | Serial uncorrectable flag |
| frame_err | output | 1 | One-cycle framing error pulse |

## Verification
The assertions assume that the three configuration inputs change only while the output stage is idle with no transfer pending. The bench changes them only after its expected-byte queue has drained and in_ready is high. The assertions also assume that the handshake inputs keep a byte stable until it is taken, so the bench holds each byte until it sees in_ready high. Malformed framing is applied on purpose: a bad marker, extra unmarked bytes and a short packet. In each case the bench expects every forwarded byte and every error pulse.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;

    typedef enum logic {
        LK_HUNT,
        LK_TRACK
    } lock_e;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_LOW,
        EM_HIGH
    } emit_e;

endpackage

// File: rtl/ts_fmt_framer.sv
module ts_fmt_framer
    import ts_fmt_pkg::*;
#(
    parameter int          PKT_LEN   = 188,
    parameter int          DW        = 8,
    parameter logic [DW-1:0] SYNC_BYTE = 8'h47
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_uncor,
    input  logic          cfg_rs_inhibit,
    input  logic          cfg_tei_inhibit,
    output logic          fwd,
    output logic [DW-1:0] fwd_byte,
    output logic          fwd_sync,
    output logic          fwd_uncor,
    output logic          frame_err
);

    localparam int            CNT_W    = $clog2(PKT_LEN);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(PKT_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_POS  = CNT_W'(1);
    localparam logic [DW-1:0]  TEI_MASK = {1'b1, {(DW-1){1'b0}}};

    lock_e            lk_q, lk_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             uncor_q, uncor_d;
    logic             err_d;
    logic             start_ok;
    logic             force_tei;

    assign start_ok = in_sop && (in_data == SYNC_BYTE);

    // lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q      <= LK_HUNT;
            cnt_q     <= '0;
            uncor_q   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            lk_q      <= lk_d;
            cnt_q     <= cnt_d;
            uncor_q   <= uncor_d;
            frame_err <= err_d;
        end
    end

    // lock transitions: acquire, restart, lose, advance
    always_comb begin
        lk_d     = lk_q;
        cnt_d    = cnt_q;
        uncor_d  = uncor_q;
        err_d    = 1'b0;
        fwd      = 1'b0;
        fwd_sync = 1'b0;
        if (take) begin
            unique case (lk_q)
                LK_HUNT: begin
                    if (start_ok) begin
                        fwd      = 1'b1;
                        fwd_sync = 1'b1;
                        lk_d     = LK_TRACK;
                        cnt_d    = HDR_POS;
                        uncor_d  = in_uncor;
                    end else if (in_sop) begin
                        err_d = 1'b1;
                    end
                end
                LK_TRACK: begin
                    if (start_ok) begin
                        fwd      = 1'b1;
                        fwd_sync = 1'b1;
                        cnt_d    = HDR_POS;
                        uncor_d  = in_uncor;
                        err_d    = (cnt_q != '0);
                    end else if (in_sop || (cnt_q == '0)) begin
                        err_d = 1'b1;
                        lk_d  = LK_HUNT;
                        cnt_d = '0;
                    end else begin
                        fwd   = 1'b1;
                        cnt_d = (cnt_q == LAST_POS) ? '0 : cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // header marking of failed packets
    always_comb begin
        force_tei = fwd && !fwd_sync && (cnt_q == HDR_POS) && uncor_q
                    && !cfg_rs_inhibit && !cfg_tei_inhibit;
        fwd_byte  = force_tei ? (in_data | TEI_MASK) : in_data;
        fwd_uncor = fwd_sync ? in_uncor : uncor_q;
    end

    AST_UNCOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q == LK_TRACK && !(take && start_ok)) |=> $stable(uncor_q))
        else $error("uncorrectable flag moved inside a packet"); // R6

    AST_TEI_ONLY_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && (fwd_byte != in_data)) |->
            (cnt_q == HDR_POS && uncor_q && !cfg_rs_inhibit && !cfg_tei_inhibit))
        else $error("byte altered outside header rule"); // R4

endmodule

// File: rtl/ts_fmt_emit.sv
module ts_fmt_emit
    import ts_fmt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_serial,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          load_sync,
    input  logic          load_uncor,
    output logic          idle,
    output logic [DW-1:0] par_data,
    output logic          par_clk,
    output logic          par_den,
    output logic          par_sync,
    output logic          par_uncor,
    output logic          ser_data,
    output logic          ser_clk,
    output logic          ser_den,
    output logic          ser_sync,
    output logic          ser_uncor
);

    localparam int             BIT_W    = $clog2(DW);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

    emit_e            st_q, st_d;
    logic [DW-1:0]    hold_q;
    logic [DW-1:0]    shift_q;
    logic [BIT_W-1:0] bit_q;
    logic             sync_q, uncor_q;
    logic             more_bits;

    assign more_bits = cfg_serial && (bit_q != LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EM_IDLE;
        else        st_q <= st_d;
    end

    // transitions: load, rise, next_bit, done
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EM_IDLE: if (load) st_d = EM_LOW;
            EM_LOW:  st_d = EM_HIGH;
            EM_HIGH: st_d = more_bits ? EM_LOW : EM_IDLE;
            default: st_d = EM_IDLE;
        endcase
    end

    // byte and bit registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            shift_q <= '0;
            bit_q   <= '0;
            sync_q  <= 1'b0;
            uncor_q <= 1'b0;
        end else if (st_q == EM_IDLE && load) begin
            shift_q <= load_byte;
            bit_q   <= '0;
            sync_q  <= load_sync;
            uncor_q <= load_uncor;
            if (!cfg_serial) hold_q <= load_byte;
        end else if (st_q == EM_HIGH && more_bits) begin
            shift_q <= shift_q << 1;
            bit_q   <= bit_q + BIT_W'(1);
        end
    end

    // outputs
    always_comb begin
        idle      = (st_q == EM_IDLE);
        par_den   = !idle && !cfg_serial;
        par_clk   = (st_q == EM_HIGH) && !cfg_serial;
        par_sync  = par_den && sync_q;
        par_uncor = par_den && uncor_q;
        par_data  = hold_q;
        ser_den   = !idle && cfg_serial;
        ser_clk   = (st_q == EM_HIGH) && cfg_serial;
        ser_sync  = ser_den && sync_q;
        ser_uncor = ser_den && uncor_q;
        ser_data  = shift_q[DW-1];
    end

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !par_den |-> $stable(par_data))
        else $error("parallel bus moved without enable"); // R5

    AST_SER_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_den && $past(ser_den) && !$past(ser_clk)) |-> $stable(ser_data))
        else $error("serial data moved off a falling clock"); // R7

endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
    import ts_fmt_pkg::*;
#(
    parameter int          PKT_LEN   = 188,
    parameter int          DW        = 8,
    parameter logic [DW-1:0] SYNC_BYTE = 8'h47
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_serial,
    input  logic          cfg_rs_inhibit,
    input  logic          cfg_tei_inhibit,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_uncor,
    output logic [DW-1:0] par_data,
    output logic          par_clk,
    output logic          par_den,
    output logic          par_sync,
    output logic          par_uncor,
    output logic          ser_data,
    output logic          ser_clk,
    output logic          ser_den,
    output logic          ser_sync,
    output logic          ser_uncor,
    output logic          frame_err
);

    logic          take;
    logic          fwd;
    logic [DW-1:0] fwd_byte;
    logic          fwd_sync;
    logic          fwd_uncor;
    logic          idle;

    assign in_ready = idle;
    assign take     = in_valid && idle;

    ts_fmt_framer #(
        .PKT_LEN  (PKT_LEN),
        .DW       (DW),
        .SYNC_BYTE(SYNC_BYTE)
    ) framer_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .take           (take),
        .in_data        (in_data),
        .in_sop         (in_sop),
        .in_uncor       (in_uncor),
        .cfg_rs_inhibit (cfg_rs_inhibit),
        .cfg_tei_inhibit(cfg_tei_inhibit),
        .fwd            (fwd),
        .fwd_byte       (fwd_byte),
        .fwd_sync       (fwd_sync),
        .fwd_uncor      (fwd_uncor),
        .frame_err      (frame_err)
    );

    ts_fmt_emit #(
        .DW(DW)
    ) emit_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_serial(cfg_serial),
        .load      (fwd),
        .load_byte (fwd_byte),
        .load_sync (fwd_sync),
        .load_uncor(fwd_uncor),
        .idle      (idle),
        .par_data  (par_data),
        .par_clk   (par_clk),
        .par_den   (par_den),
        .par_sync  (par_sync),
        .par_uncor (par_uncor),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_den   (ser_den),
        .ser_sync  (ser_sync),
        .ser_uncor (ser_uncor)
    );

    AST_SYNC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        par_sync |-> (par_data == SYNC_BYTE))
        else $error("sync pulse on a non-sync byte"); // R2

endmodule

// File: tb/ts_out_fmt_tb.sv
module ts_out_fmt_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0;
    logic       cfg_rs_inhibit = 1'b0;
    logic       cfg_tei_inhibit = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sop = 1'b0;
    logic       in_uncor = 1'b0;
    logic [7:0] par_data;
    logic       par_clk, par_den, par_sync, par_uncor;
    logic       ser_data, ser_clk, ser_den, ser_sync, ser_uncor;
    logic       frame_err;

    always #10 clk = ~clk;

    ts_out_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial),
        .cfg_rs_inhibit(cfg_rs_inhibit), .cfg_tei_inhibit(cfg_tei_inhibit),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_uncor(in_uncor),
        .par_data(par_data), .par_clk(par_clk), .par_den(par_den),
        .par_sync(par_sync), .par_uncor(par_uncor),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_den(ser_den),
        .ser_sync(ser_sync), .ser_uncor(ser_uncor), .frame_err(frame_err)
    );

    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    int         err_seen = 0;
    int         exp_err = 0;
    int         sbits = 0;
    logic       run_mon = 1'b0;
    logic [7:0] prev_par = 8'h00;
    logic       prev_ser = 1'b0;
    logic [7:0] acc = 8'h00;
    logic [9:0] exp_q[$];   // {sync, uncor, byte}
    string      tag_q[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // reference comparison, every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_mon) begin
            logic [9:0] e;
            string      t;
            if (frame_err) err_seen++;
            if (cfg_serial) chk("R8 parallel quiet in serial mode", par_den, 0);
            else            chk("R8 serial quiet in parallel mode", ser_den, 0);
            if (!par_den) begin
                chk("R5 par_sync low without enable", par_sync, 0);
                chk("R5 par_uncor low without enable", par_uncor, 0);
                chk("R5 par_data holds without enable", par_data, prev_par);
            end
            if (!ser_den) begin
                chk("R5 ser_sync low without enable", ser_sync, 0);
                chk("R5 ser_uncor low without enable", ser_uncor, 0);
            end
            if (par_clk) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R1 unexpected byte actual=%0h expected=none", par_data);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " parallel byte"}, par_data, e[7:0]);
                    chk("R2 parallel sync", par_sync, e[9]);
                    chk("R3 parallel uncor", par_uncor, e[8]);
                    chk("R5 enable with clock", par_den, 1);
                end
            end
            if (ser_clk) begin
                chk("R7 data stable across rising clock", ser_data, prev_ser);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7 unexpected serial bit actual=%0h expected=none", ser_data);
                end else begin
                    e = exp_q[0];
                    chk("R7 serial sync per bit", ser_sync, e[9]);
                    chk("R7 serial uncor per bit", ser_uncor, e[8]);
                    acc = {acc[6:0], ser_data};
                    sbits++;
                    if (sbits == 8) begin
                        sbits = 0;
                        void'(exp_q.pop_front());
                        t = tag_q.pop_front();
                        chk({t, " R7 serial byte"}, acc, e[7:0]);
                    end
                end
            end
            prev_par = par_data;
            prev_ser = ser_data;
        end
    end

    task automatic send_raw(logic [7:0] b, logic sop, logic unc);
        in_valid = 1'b1;
        in_data  = b;
        in_sop   = sop;
        in_uncor = unc;
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic send_packet(int id, int nbytes, logic unc, int flip_at, string tag);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] b;
            logic [7:0] eb;
            logic       drive_unc;
            if (i == 0)      b = 8'h47;
            else if (i == 1) b = 8'h01 + 8'(id);
            else             b = 8'((id * 31 + i * 13) & 255);
            eb = b;
            if (i == 1 && unc && !cfg_rs_inhibit && !cfg_tei_inhibit) eb = b | 8'h80;
            exp_q.push_back({(i == 0), unc, eb});
            tag_q.push_back(i == 0 ? "R2" : (i == 1 ? {"R4 ", tag} : tag));
            drive_unc = (flip_at >= 0 && i >= flip_at) ? !unc : unc;
            send_raw(b, (i == 0), drive_unc);
        end
    endtask

    task automatic drain();
        for (int t = 0; t < 20000; t++) begin
            if (exp_q.size() == 0 && in_ready) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk("R1 all expected bytes emitted", exp_q.size(), 0);
    endtask

    task automatic run_tests();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset in_ready", in_ready, 1);
        chk("R5 reset par_den", par_den, 0);
        chk("R8 reset ser_den", ser_den, 0);
        chk("R9 reset frame_err", frame_err, 0);
        chk("R5 reset par_data", par_data, 0);
        run_mon = 1'b1;

        send_packet(1, 188, 1'b0, -1, "R1");
        send_packet(2, 188, 1'b1, -1, "R3");
        repeat (10) @(negedge clk);
        drain();
        cfg_rs_inhibit = 1'b1;
        send_packet(3, 188, 1'b1, -1, "R4 rs_inhibit");
        drain();
        cfg_rs_inhibit = 1'b0;
        cfg_tei_inhibit = 1'b1;
        send_packet(4, 188, 1'b1, -1, "R4 tei_inhibit");
        drain();
        cfg_tei_inhibit = 1'b0;
        send_packet(5, 188, 1'b0, 50, "R6");
        send_packet(6, 188, 1'b1, 2, "R6");
        drain();

        send_raw(8'h00, 1'b1, 1'b0);   // bad marker: error, hunt
        exp_err++;
        send_raw(8'h55, 1'b0, 1'b0);   // dropped silently
        send_raw(8'h47, 1'b0, 1'b0);   // unmarked sync value dropped
        send_packet(7, 188, 1'b0, -1, "R9 after bad marker");
        drain();
        chk("R9 error pulses after bad marker", err_seen, exp_err);

        send_packet(8, 100, 1'b0, -1, "R9 short");
        send_packet(9, 188, 1'b1, -1, "R9 restart");
        exp_err++;
        drain();
        chk("R9 error pulses after short packet", err_seen, exp_err);

        send_raw(8'hAA, 1'b0, 1'b0);   // too long: error, hunt
        exp_err++;
        send_raw(8'h12, 1'b1, 1'b0);   // bad marker in hunt
        exp_err++;
        send_packet(10, 188, 1'b0, -1, "R9 after long");
        drain();
        chk("R9 error pulses after long packet", err_seen, exp_err);

        cfg_serial = 1'b1;
        repeat (2) @(negedge clk);
        send_packet(11, 188, 1'b1, -1, "R7");
        repeat (7) @(negedge clk);
        send_packet(12, 188, 1'b0, -1, "R7");
        drain();
        chk("R7 no partial serial byte", sbits, 0);
        chk("R9 final error pulse count", err_seen, exp_err);
    endtask

    initial begin
        fork
            run_tests();
            begin
                wait (cyc >= 150000);
                checks++; errors++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule